// File: doc/BRIEF.md
# CAN Receive Mailbox Acceptance Filter

This block decides whether a received CAN frame is accepted by one receive mailbox. It takes the frame's 29-bit identifier and its extended-format and remote-request flags, the mailbox's stored filter identifier and flags, and a per-mailbox mask word. It returns one match flag. The match is combinational from these inputs and from a registered comparison-policy bit. The flag is also gated by an input that says whether the mailbox is currently armed for reception.

The policy bit selects how the two frame flags take part in the decision. With the bit clear, the extended-format flag must always equal the filter's flag, and the remote-request flag plays no part; the two mask bits that belong to the flags are disregarded. With the bit set, both flags are compared, and each comparison is enabled by its own mask bit. The policy bit can be loaded only while the controller is frozen. A write request at any other time leaves the bit unchanged. The bit governs mailbox filters only.

Top module: `can_mbox_filter`

## Requirements
- R1: After a synchronous reset, the policy bit `mode_o` reads 0.
- R2: A write with `freeze_i`=1 and `mode_wr_i`=1 at a rising edge loads `mode_wdata_i` into `mode_o`, and the new value is visible after that edge.
- R3: A write with `freeze_i`=0 leaves `mode_o` unchanged.
- R4: A mask bit `mask_i[k]` of 1 (for k from 0 to 28) requires the frame and filter identifier bits k to be equal. A mask bit of 0 makes bit k a don't-care.
- R5: For a standard frame (`rx_ide_i`=0), only identifier bits 28..18 are compared. The standard identifier sits in those upper 11 bits, and differences in bits 17..0 never reject the frame.
- R6: For an extended frame (`rx_ide_i`=1), all 29 identifier bits 28..0 are compared under the mask.
- R7: With `mode_o`=0, a difference between `rx_ide_i` and `flt_ide_i` always gives no match, whatever the IDE mask bit `mask_i[30]` holds.
- R8: With `mode_o`=0, `rx_rtr_i` and `flt_rtr_i` never affect the match, whatever the RTR mask bit `mask_i[29]` holds.
- R9: With `mode_o`=1, the IDE flags must be equal when `mask_i[30]`=1 and the RTR flags must be equal when `mask_i[29]`=1. A flag whose mask bit is 0 is a don't-care.
- R10: `match_o` is 0 whenever `rx_active_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze_i | input | 1 | Controller is in the frozen state |
| mode_wr_i | input | 1 | Write strobe for the policy bit |
| mode_wdata_i | input | 1 | Value to write into the policy bit |
| mode_o | output | 1 | Current policy bit |
| rx_id_i | input | 29 | Received identifier (standard identifier in bits 28..18) |
| rx_ide_i | input | 1 | Received frame is in extended format |
| rx_rtr_i | input | 1 | Received frame is a remote request |
| flt_id_i | input | 29 | Filter identifier of the mailbox |
| flt_ide_i | input | 1 | Filter extended-format flag |
| flt_rtr_i | input | 1 | Filter remote-request flag |
| mask_i | input | 31 | Mask: bits 28..0 cover the identifier, bit 29 covers RTR, bit 30 covers IDE |
| rx_active_i | input | 1 | Mailbox is armed for reception |
| match_o | output | 1 | Frame is accepted by this mailbox |

## Verification
The match flag has no register on its path, so it is due in the same cycle as its inputs. The bench drives the frame, filter and mask fields at a falling edge and samples `match_o` one nanosecond later, well before the next rising edge. The policy bit takes one register stage, so each write is presented at a falling edge and `mode_o` is read at the falling edge that follows the capturing rising edge. Every flag combination is then swept under each setting of the policy bit.

// File: rtl/can_mbf_pkg.sv
package can_mbf_pkg;

    // Identifier geometry
    localparam int ID_W   = 29;
    localparam int STD_W  = 11;
    localparam int STD_LO = ID_W - STD_W;

    // Mask word layout: identifier bits, then RTR, then IDE
    localparam int MASK_RTR_BIT = ID_W;
    localparam int MASK_IDE_BIT = ID_W + 1;
    localparam int MASK_W       = ID_W + 2;

    typedef enum logic {
        POL_IDE_FIXED  = 1'b0,
        POL_FLAGS_MASK = 1'b1
    } flag_policy_e;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            ide;
        logic            rtr;
    } frame_hdr_t;

    typedef struct packed {
        logic            ide_care;
        logic            rtr_care;
        logic [ID_W-1:0] id_care;
    } mask_word_t;

    function automatic mask_word_t unpack_mask(input logic [MASK_W-1:0] raw);
        mask_word_t m;
        m.ide_care = raw[MASK_IDE_BIT];
        m.rtr_care = raw[MASK_RTR_BIT];
        m.id_care  = raw[ID_W-1:0];
        return m;
    endfunction

    function automatic logic flag_ok(input logic a, input logic b, input logic care);
        return (~care) | (a ~^ b);
    endfunction

endpackage

// File: rtl/can_mbf_cfg.sv
module can_mbf_cfg
    import can_mbf_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         freeze_i,
    input  logic         wr_i,
    input  logic         wdata_i,
    output flag_policy_e pol_o
);

    flag_policy_e pol_q;
    logic         wr_ok;

    // A write is accepted only in the frozen state
    assign wr_ok = freeze_i & wr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= POL_IDE_FIXED;
        end else if (wr_ok) begin
            pol_q <= flag_policy_e'(wdata_i);
        end
    end

    assign pol_o = pol_q;

endmodule

// File: rtl/can_mbf_id_cmp.sv
module can_mbf_id_cmp
    import can_mbf_pkg::*;
#(
    parameter int W     = ID_W,
    parameter int STD_N = STD_W
) (
    input  logic [W-1:0] rx_id_i,
    input  logic [W-1:0] flt_id_i,
    input  logic [W-1:0] care_i,
    input  logic         ext_i,
    output logic         ok_o
);

    localparam int LO = W - STD_N;

    logic [W-1:0] bit_ok;
    logic [W-1:0] in_scope;

    for (genvar k = 0; k < W; k++) begin : g_bit
        assign bit_ok[k] = (~care_i[k]) | (rx_id_i[k] ~^ flt_id_i[k]);
        if (k >= LO) begin : g_std
            assign in_scope[k] = 1'b1;
        end else begin : g_ext
            assign in_scope[k] = ext_i;
        end
    end

    assign ok_o = &(bit_ok | ~in_scope);

endmodule

// File: rtl/can_mbf_flag_cmp.sv
module can_mbf_flag_cmp
    import can_mbf_pkg::*;
(
    input  flag_policy_e pol_i,
    input  frame_hdr_t   rx_i,
    input  frame_hdr_t   flt_i,
    input  mask_word_t   mask_i,
    output logic         ok_o
);

    logic ide_ok;
    logic rtr_ok;

    always_comb begin
        unique case (pol_i)
            POL_IDE_FIXED: begin
                ide_ok = flag_ok(rx_i.ide, flt_i.ide, 1'b1);
                rtr_ok = 1'b1;
            end
            POL_FLAGS_MASK: begin
                ide_ok = flag_ok(rx_i.ide, flt_i.ide, mask_i.ide_care);
                rtr_ok = flag_ok(rx_i.rtr, flt_i.rtr, mask_i.rtr_care);
            end
            default: begin
                ide_ok = 1'b0;
                rtr_ok = 1'b0;
            end
        endcase
    end

    assign ok_o = ide_ok & rtr_ok;

endmodule

// File: rtl/can_mbox_filter.sv
module can_mbox_filter
    import can_mbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              freeze_i,
    input  logic              mode_wr_i,
    input  logic              mode_wdata_i,
    output logic              mode_o,
    input  logic [ID_W-1:0]   rx_id_i,
    input  logic              rx_ide_i,
    input  logic              rx_rtr_i,
    input  logic [ID_W-1:0]   flt_id_i,
    input  logic              flt_ide_i,
    input  logic              flt_rtr_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic              rx_active_i,
    output logic              match_o
);

    flag_policy_e pol;
    frame_hdr_t   rx_hdr;
    frame_hdr_t   flt_hdr;
    mask_word_t   mask;
    logic         id_ok;
    logic         flags_ok;

    assign rx_hdr  = '{id: rx_id_i,  ide: rx_ide_i,  rtr: rx_rtr_i};
    assign flt_hdr = '{id: flt_id_i, ide: flt_ide_i, rtr: flt_rtr_i};
    assign mask    = unpack_mask(mask_i);

    can_mbf_cfg i_cfg (
        .clk      (clk),
        .rst      (rst),
        .freeze_i (freeze_i),
        .wr_i     (mode_wr_i),
        .wdata_i  (mode_wdata_i),
        .pol_o    (pol)
    );

    can_mbf_id_cmp #(
        .W     (ID_W),
        .STD_N (STD_W)
    ) i_id_cmp (
        .rx_id_i  (rx_hdr.id),
        .flt_id_i (flt_hdr.id),
        .care_i   (mask.id_care),
        .ext_i    (rx_hdr.ide),
        .ok_o     (id_ok)
    );

    can_mbf_flag_cmp i_flag_cmp (
        .pol_i  (pol),
        .rx_i   (rx_hdr),
        .flt_i  (flt_hdr),
        .mask_i (mask),
        .ok_o   (flags_ok)
    );

    assign mode_o  = pol;
    assign match_o = rx_active_i & id_ok & flags_ok;

endmodule

// File: rtl/can_mbox_filter_chk.sv
module can_mbox_filter_chk
    import can_mbf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              freeze_i,
    input logic              mode_wr_i,
    input logic              mode_wdata_i,
    input logic              mode_o,
    input logic              rx_ide_i,
    input logic              flt_ide_i,
    input logic              rx_rtr_i,
    input logic              flt_rtr_i,
    input logic [MASK_W-1:0] mask_i,
    input logic              rx_active_i,
    input logic              match_o
);

    assert_reset_mode_R1: assert property (@(posedge clk)
        rst |=> !mode_o);

    assert_frozen_load_R2: assert property (@(posedge clk) disable iff (rst)
        (freeze_i && mode_wr_i) |=> (mode_o == $past(mode_wdata_i)));

    assert_unfrozen_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(freeze_i && mode_wr_i) |=> $stable(mode_o));

    assert_ide_forced_R7: assert property (@(posedge clk) disable iff (rst)
        (!mode_o && (rx_ide_i != flt_ide_i)) |-> !match_o);

    assert_flags_masked_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_o && ((mask_i[MASK_IDE_BIT] && (rx_ide_i != flt_ide_i)) ||
                    (mask_i[MASK_RTR_BIT] && (rx_rtr_i != flt_rtr_i)))) |-> !match_o);

    assert_inactive_R10: assert property (@(posedge clk) disable iff (rst)
        !rx_active_i |-> !match_o);

endmodule

bind can_mbox_filter can_mbox_filter_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .freeze_i     (freeze_i),
    .mode_wr_i    (mode_wr_i),
    .mode_wdata_i (mode_wdata_i),
    .mode_o       (mode_o),
    .rx_ide_i     (rx_ide_i),
    .flt_ide_i    (flt_ide_i),
    .rx_rtr_i     (rx_rtr_i),
    .flt_rtr_i    (flt_rtr_i),
    .mask_i       (mask_i),
    .rx_active_i  (rx_active_i),
    .match_o      (match_o)
);

// File: tb/test_can_mbox_filter.sv
`timescale 1ns/1ps
module test_can_mbox_filter;

    logic        clk = 1'b0;
    logic        rst;
    logic        freeze_i, mode_wr_i, mode_wdata_i;
    logic        mode_o;
    logic [28:0] rx_id_i, flt_id_i;
    logic        rx_ide_i, rx_rtr_i, flt_ide_i, flt_rtr_i;
    logic [30:0] mask_i;
    logic        rx_active_i;
    logic        match_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    can_mbox_filter i_can_mbox_filter (
        .clk(clk), .rst(rst), .freeze_i(freeze_i), .mode_wr_i(mode_wr_i),
        .mode_wdata_i(mode_wdata_i), .mode_o(mode_o), .rx_id_i(rx_id_i),
        .rx_ide_i(rx_ide_i), .rx_rtr_i(rx_rtr_i), .flt_id_i(flt_id_i),
        .flt_ide_i(flt_ide_i), .flt_rtr_i(flt_rtr_i), .mask_i(mask_i),
        .rx_active_i(rx_active_i), .match_o(match_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic write_mode(input logic frz, input logic val);
        @(negedge clk);
        freeze_i = frz; mode_wr_i = 1'b1; mode_wdata_i = val;
        @(negedge clk);
        freeze_i = 1'b0; mode_wr_i = 1'b0; mode_wdata_i = 1'b0;
    endtask

    // Expected match from the requirements
    function automatic logic expect_match(input logic md, input logic act,
            input logic [28:0] rid, input logic [28:0] fid, input logic [30:0] m,
            input logic ride, input logic fide, input logic rrtr, input logic frtr);
        logic [28:0] diff;
        logic        id_good, ide_good, rtr_good;
        diff = (rid ^ fid) & m[28:0];
        id_good = ride ? (diff == 29'd0) : (diff[28:18] == 11'd0);
        if (!md) begin
            ide_good = (ride == fide);
            rtr_good = 1'b1;
        end else begin
            ide_good = !m[30] || (ride == fide);
            rtr_good = !m[29] || (rrtr == frtr);
        end
        return act && id_good && ide_good && rtr_good;
    endfunction

    task automatic sweep(input logic md);
        for (int pat = 0; pat < 4; pat++) begin
            for (int f = 0; f < 256; f++) begin
                string tag;
                logic  e;
                @(negedge clk);
                rx_id_i = 29'h0ACE_5171;
                mask_i  = {f[5], f[6], 29'h1FFF_FFFF};
                case (pat)
                    0: flt_id_i = rx_id_i;
                    1: flt_id_i = rx_id_i ^ 29'h0000_0001;
                    2: flt_id_i = rx_id_i ^ (29'd1 << 25);
                    default: begin
                        flt_id_i = rx_id_i ^ (29'd1 << 25);
                        mask_i[25] = 1'b0;
                    end
                endcase
                rx_ide_i    = f[0];
                rx_rtr_i    = f[1];
                flt_ide_i   = f[2];
                flt_rtr_i   = f[3];
                rx_active_i = f[4];
                if (f[7]) mask_i[28:0] = 29'd0;
                #1;
                e = expect_match(md, rx_active_i, rx_id_i, flt_id_i, mask_i,
                                 rx_ide_i, flt_ide_i, rx_rtr_i, flt_rtr_i);
                if (!rx_active_i)                         tag = "R10";
                else if (!md && rx_ide_i != flt_ide_i)    tag = "R7";
                else if (!md && rx_rtr_i != flt_rtr_i)    tag = "R8";
                else if (md && (rx_ide_i != flt_ide_i || rx_rtr_i != flt_rtr_i)) tag = "R9";
                else if (pat == 1 && !rx_ide_i)           tag = "R5";
                else if (pat == 1 || pat == 2)            tag = (rx_ide_i ? "R6" : "R5");
                else                                      tag = "R4";
                check(tag, match_o, e);
            end
        end
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; freeze_i = 1'b0; mode_wr_i = 1'b0; mode_wdata_i = 1'b0;
        rx_id_i = '0; flt_id_i = '0; rx_ide_i = 0; rx_rtr_i = 0;
        flt_ide_i = 0; flt_rtr_i = 0; mask_i = '0; rx_active_i = 0;
        repeat (3) @(negedge clk);
        check("R1", mode_o, 1'b0);
        rst = 1'b0;

        write_mode(1'b0, 1'b1);
        check("R3", mode_o, 1'b0);
        sweep(1'b0);

        write_mode(1'b1, 1'b1);
        check("R2", mode_o, 1'b1);
        write_mode(1'b0, 1'b0);
        check("R3", mode_o, 1'b1);
        sweep(1'b1);

        write_mode(1'b1, 1'b0);
        check("R2", mode_o, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule